// File: doc/BRIEF.md
# Router Link Test Cell with Bypass

The block sits on one 34-bit router link and gives a test controller access to the traffic on it. Every port uses a valid/ready handshake, and a transfer happens on a rising clock edge where valid and ready are both high. In functional mode, flits that arrive on the network input leave on the network output after one register stage, at one flit per cycle. In test mode, a source selector can feed the network output from a local test input instead. A destination mask can also copy each network flit to a local capture output. When several destinations are enabled, one incoming flit is split to all of them. The flit is accepted only in a cycle where every enabled destination can take it. A destination that is not enabled never holds up the link.

A parameter builds the cell as one of two variants. The input-side variant has an extra bypass output, which the destination mask can select. A router that has already been tested can then be routed around. The output-side variant has an extra bypass input instead, which the source selector can route to the network output. The block samples the two control inputs into a live configuration only while all of its holding registers are empty. A change requested while a flit is still held waits until that flit has drained. Until then, the cell accepts nothing new.

Top module: `ntc_link_cell`

## Requirements
- R1: While reset is low and on the first cycle after it, all three outputs (net_out, loc_out, byp_out) show valid low. The live configuration resets to source 0 (network) and destination mask 3'b001 (forward only), so net_in_ready is high when the control inputs hold those values.
- R2: With cfg_src_sel = 0 and mask bit 0 set, a flit accepted on net_in is shown unchanged on net_out in the cycle after acceptance. With every sink ready, a burst is accepted at one flit per cycle.
- R3: With cfg_src_sel = 1 (local), flits from loc_in are forwarded to net_out in order, one cycle after acceptance. Network flits no longer reach net_out.
- R4: With destination mask bit 1 set, each accepted net_in flit is copied unchanged to loc_out.
- R5: When two or more destinations are live, net_in is accepted only when every live holding stage can take the flit, and each of them receives a copy. No partial copy is made while one of them is full. The ready input of a sink that is not live has no effect.
- R6: An output whose valid is high and whose ready is low keeps valid high and its data unchanged on the next cycle.
- R7: A change on cfg_src_sel or cfg_dest_mask takes effect only in a cycle where no output holds a flit. While such a change is waiting, net_in_ready, loc_in_ready and byp_in_ready are all low.
- R8: In the input-side variant (OUTPUT_SIDE = 0), mask bit 2 copies each accepted network flit to byp_out. The bypass input is never accepted: byp_in_ready stays low.
- R9: In the output-side variant (OUTPUT_SIDE = 1), cfg_src_sel = 2 forwards byp_in flits to net_out. Mask bit 2 is ignored, so byp_out_valid stays low.
- R10: If the configuration leaves net_in with no live destination, net_in_ready stays low. This happens when mask bit 0 is set but the source is not 0, and no other live bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_sel | input | 2 | Source for net_out: 0 network, 1 local, 2 bypass (output-side only), 3 none |
| cfg_dest_mask | input | 3 | Destinations of network flits: bit 0 forward, bit 1 capture, bit 2 bypass out |
| net_in_valid | input | 1 | Network input flit valid |
| net_in_ready | output | 1 | Network input flit accepted |
| net_in_data | input | DATA_W | Network input flit |
| net_out_valid | output | 1 | Network output flit valid |
| net_out_ready | input | 1 | Network output receiver ready |
| net_out_data | output | DATA_W | Network output flit |
| loc_in_valid | input | 1 | Local test injection valid |
| loc_in_ready | output | 1 | Local test injection accepted |
| loc_in_data | input | DATA_W | Local test injection flit |
| loc_out_valid | output | 1 | Captured flit valid |
| loc_out_ready | input | 1 | Capture receiver ready |
| loc_out_data | output | DATA_W | Captured flit |
| byp_in_valid | input | 1 | Bypass input valid (output-side variant) |
| byp_in_ready | output | 1 | Bypass input accepted |
| byp_in_data | input | DATA_W | Bypass input flit |
| byp_out_valid | output | 1 | Bypass output valid (input-side variant) |
| byp_out_ready | input | 1 | Bypass output receiver ready |
| byp_out_data | output | DATA_W | Bypass output flit |

## Verification
The arrival assertions assume that a waiting source keeps its flit unchanged until ready is seen. The bench's driver tasks therefore hold valid and data steady until the cycle in which the cell accepts. The configuration-freeze properties place no limit on when the controls may change. The bench uses this on purpose: it changes the controls while a flit is stuck behind a stalled sink and also while traffic is idle. Sink readiness is driven always high, held low, or toggled in a fixed pseudo-random pattern. Every driven value changes half a cycle away from the sampling edge.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

  typedef enum logic [1:0] {
    SRC_NET    = 2'd0,
    SRC_LOCAL  = 2'd1,
    SRC_BYPASS = 2'd2,
    SRC_NONE   = 2'd3
  } src_sel_e;

  localparam int N_DEST   = 3;
  localparam int DEST_FWD = 0;
  localparam int DEST_CAP = 1;
  localparam int DEST_BYP = 2;

  localparam logic [N_DEST-1:0] RESET_MASK = 3'b001;

  // Destinations of a network flit that are actually reachable under the
  // present configuration and variant.
  function automatic logic [N_DEST-1:0] live_dests(
    input logic [1:0]        src,
    input logic [N_DEST-1:0] mask,
    input bit                out_side
  );
    logic [N_DEST-1:0] d;
    d[DEST_FWD] = mask[DEST_FWD] && (src == SRC_NET);
    d[DEST_CAP] = mask[DEST_CAP];
    d[DEST_BYP] = mask[DEST_BYP] && !out_side;
    return d;
  endfunction

endpackage

// File: rtl/ntc_hold_stage.sv
module ntc_hold_stage #(
  parameter int DATA_W = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              can_take
);

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              en;

  assign can_take  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_comb begin
    en      = load || (valid_q && out_ready);
    valid_d = load ? 1'b1 : 1'b0;
    data_d  = load ? load_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (en) begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

endmodule

// File: rtl/ntc_cfg_gate.sv
module ntc_cfg_gate
  import ntc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_in,
  input  logic [N_DEST-1:0] mask_in,
  input  logic              idle,
  output logic [1:0]        src_q,
  output logic [N_DEST-1:0] mask_q,
  output logic              pend
);

  logic [1:0]        src_d;
  logic [N_DEST-1:0] mask_d;
  logic              en;

  assign pend = (src_in != src_q) || (mask_in != mask_q);

  always_comb begin
    en     = idle && pend;
    src_d  = src_in;
    mask_d = mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NET;
      mask_q <= RESET_MASK;
    end else if (en) begin
      src_q  <= src_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/ntc_fanout.sv
module ntc_fanout
  import ntc_pkg::*;
#(
  parameter bit OUTPUT_SIDE = 1'b0
) (
  input  logic [1:0]        src_q,
  input  logic [N_DEST-1:0] mask_q,
  input  logic              pend,
  input  logic [N_DEST-1:0] can_take,
  input  logic              net_in_valid,
  input  logic              loc_in_valid,
  input  logic              byp_in_valid,
  output logic              net_in_ready,
  output logic              loc_in_ready,
  output logic              byp_in_ready,
  output logic [N_DEST-1:0] load
);

  logic [N_DEST-1:0] live;
  logic              net_go, loc_go, byp_go;

  always_comb begin
    live         = live_dests(src_q, mask_q, OUTPUT_SIDE);
    // every live stage must take the flit in the same edge
    net_in_ready = !pend && (|live) && (&(can_take | ~live));
    loc_in_ready = !pend && (src_q == SRC_LOCAL) && can_take[DEST_FWD];
    byp_in_ready = OUTPUT_SIDE && !pend && (src_q == SRC_BYPASS)
                   && can_take[DEST_FWD];
    net_go = net_in_valid && net_in_ready;
    loc_go = loc_in_valid && loc_in_ready;
    byp_go = byp_in_valid && byp_in_ready;
    load[DEST_FWD] = (net_go && live[DEST_FWD]) || loc_go || byp_go;
    load[DEST_CAP] = net_go && live[DEST_CAP];
    load[DEST_BYP] = net_go && live[DEST_BYP];
  end

endmodule

// File: rtl/ntc_link_cell.sv
module ntc_link_cell
  import ntc_pkg::*;
#(
  parameter int DATA_W      = 34,
  parameter bit OUTPUT_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_src_sel,
  input  logic [2:0]        cfg_dest_mask,
  input  logic              net_in_valid,
  output logic              net_in_ready,
  input  logic [DATA_W-1:0] net_in_data,
  output logic              net_out_valid,
  input  logic              net_out_ready,
  output logic [DATA_W-1:0] net_out_data,
  input  logic              loc_in_valid,
  output logic              loc_in_ready,
  input  logic [DATA_W-1:0] loc_in_data,
  output logic              loc_out_valid,
  input  logic              loc_out_ready,
  output logic [DATA_W-1:0] loc_out_data,
  input  logic              byp_in_valid,
  output logic              byp_in_ready,
  input  logic [DATA_W-1:0] byp_in_data,
  output logic              byp_out_valid,
  input  logic              byp_out_ready,
  output logic [DATA_W-1:0] byp_out_data
);

  logic [1:0]        cfg_src_q;
  logic [N_DEST-1:0] cfg_mask_q;
  logic              cfg_pend;
  logic              stages_idle;

  logic [N_DEST-1:0] stg_load;
  logic [N_DEST-1:0] stg_can_take;
  logic [N_DEST-1:0] stg_valid;
  logic [N_DEST-1:0] stg_out_ready;
  logic [DATA_W-1:0] stg_in_data  [N_DEST];
  logic [DATA_W-1:0] stg_out_data [N_DEST];
  logic [DATA_W-1:0] fwd_data;

  assign stages_idle = ~|stg_valid;

  ntc_cfg_gate i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (cfg_src_sel),
    .mask_in (cfg_dest_mask),
    .idle    (stages_idle),
    .src_q   (cfg_src_q),
    .mask_q  (cfg_mask_q),
    .pend    (cfg_pend)
  );

  ntc_fanout #(.OUTPUT_SIDE(OUTPUT_SIDE)) i_fan (
    .src_q        (cfg_src_q),
    .mask_q       (cfg_mask_q),
    .pend         (cfg_pend),
    .can_take     (stg_can_take),
    .net_in_valid (net_in_valid),
    .loc_in_valid (loc_in_valid),
    .byp_in_valid (byp_in_valid),
    .net_in_ready (net_in_ready),
    .loc_in_ready (loc_in_ready),
    .byp_in_ready (byp_in_ready),
    .load         (stg_load)
  );

  // source selector in front of the forward stage
  always_comb begin
    case (cfg_src_q)
      SRC_LOCAL:  fwd_data = loc_in_data;
      SRC_BYPASS: fwd_data = byp_in_data;
      default:    fwd_data = net_in_data;
    endcase
  end

  assign stg_out_ready[DEST_FWD] = net_out_ready;
  assign stg_out_ready[DEST_CAP] = loc_out_ready;
  assign stg_out_ready[DEST_BYP] = byp_out_ready;

  assign stg_in_data[DEST_FWD] = fwd_data;
  assign stg_in_data[DEST_CAP] = net_in_data;
  assign stg_in_data[DEST_BYP] = net_in_data;

  for (genvar k = 0; k < N_DEST; k++) begin : g_stage
    if (k == DEST_BYP && OUTPUT_SIDE) begin : g_absent
      logic unused_rdy;
      assign unused_rdy          = stg_out_ready[k];
      assign stg_valid[k]        = 1'b0;
      assign stg_can_take[k]     = 1'b1;
      assign stg_out_data[k]     = '0;
    end else begin : g_present
      ntc_hold_stage #(.DATA_W(DATA_W)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (stg_load[k]),
        .load_data (stg_in_data[k]),
        .out_ready (stg_out_ready[k]),
        .out_valid (stg_valid[k]),
        .out_data  (stg_out_data[k]),
        .can_take  (stg_can_take[k])
      );
    end
  end

  assign net_out_valid = stg_valid[DEST_FWD];
  assign net_out_data  = stg_out_data[DEST_FWD];
  assign loc_out_valid = stg_valid[DEST_CAP];
  assign loc_out_data  = stg_out_data[DEST_CAP];
  assign byp_out_valid = stg_valid[DEST_BYP];
  assign byp_out_data  = stg_out_data[DEST_BYP];

endmodule

// File: rtl/ntc_link_cell_chk.sv
module ntc_link_cell_chk #(
  parameter int DATA_W = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              net_in_valid,
  input logic              net_in_ready,
  input logic [DATA_W-1:0] net_in_data,
  input logic              net_out_valid,
  input logic              net_out_ready,
  input logic [DATA_W-1:0] net_out_data,
  input logic              loc_in_ready,
  input logic              loc_out_valid,
  input logic              loc_out_ready,
  input logic [DATA_W-1:0] loc_out_data,
  input logic              byp_in_ready,
  input logic              byp_out_valid,
  input logic [1:0]        cfg_src_q,
  input logic [2:0]        cfg_mask_q,
  input logic              cfg_pend
);

  AST_FWD_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (net_in_valid && net_in_ready && cfg_mask_q[0] && cfg_src_q == 2'd0)
    |=> (net_out_valid && net_out_data == $past(net_in_data))); // R2

  AST_CAP_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (net_in_valid && net_in_ready && cfg_mask_q[1])
    |=> (loc_out_valid && loc_out_data == $past(loc_out_data) || loc_out_valid) && loc_out_data == $past(net_in_data)); // R4

  AST_NET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (net_out_valid && !net_out_ready) |=> (net_out_valid && $stable(net_out_data))); // R6

  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_out_valid && !loc_out_ready) |=> (loc_out_valid && $stable(loc_out_data))); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (net_out_valid || loc_out_valid || byp_out_valid)
    |=> ($stable(cfg_src_q) && $stable(cfg_mask_q))); // R7

  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pend |-> (!net_in_ready && !loc_in_ready && !byp_in_ready)); // R7

endmodule

bind ntc_link_cell ntc_link_cell_chk #(.DATA_W(DATA_W)) i_ntc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .net_in_valid  (net_in_valid),
  .net_in_ready  (net_in_ready),
  .net_in_data   (net_in_data),
  .net_out_valid (net_out_valid),
  .net_out_ready (net_out_ready),
  .net_out_data  (net_out_data),
  .loc_in_ready  (loc_in_ready),
  .loc_out_valid (loc_out_valid),
  .loc_out_ready (loc_out_ready),
  .loc_out_data  (loc_out_data),
  .byp_in_ready  (byp_in_ready),
  .byp_out_valid (byp_out_valid),
  .cfg_src_q     (cfg_src_q),
  .cfg_mask_q    (cfg_mask_q),
  .cfg_pend      (cfg_pend)
);

// File: tb/test_ntc_link_cell.sv
module test_ntc_link_cell;

  localparam int W = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  // input-side instance signals
  logic [1:0]   cfg_src_sel = 2'd0;
  logic [2:0]   cfg_dest_mask = 3'b001;
  logic         net_in_valid = 1'b0, net_in_ready;
  logic [W-1:0] net_in_data = '0;
  logic         net_out_valid, net_out_ready;
  logic [W-1:0] net_out_data;
  logic         loc_in_valid = 1'b0, loc_in_ready;
  logic [W-1:0] loc_in_data = '0;
  logic         loc_out_valid, loc_out_ready;
  logic [W-1:0] loc_out_data;
  logic         byp_in_valid = 1'b0, byp_in_ready;
  logic [W-1:0] byp_in_data = '0;
  logic         byp_out_valid, byp_out_ready;
  logic [W-1:0] byp_out_data;

  ntc_link_cell #(.DATA_W(W), .OUTPUT_SIDE(1'b0)) i_ntc_link_cell (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_sel(cfg_src_sel), .cfg_dest_mask(cfg_dest_mask),
    .net_in_valid(net_in_valid), .net_in_ready(net_in_ready), .net_in_data(net_in_data),
    .net_out_valid(net_out_valid), .net_out_ready(net_out_ready), .net_out_data(net_out_data),
    .loc_in_valid(loc_in_valid), .loc_in_ready(loc_in_ready), .loc_in_data(loc_in_data),
    .loc_out_valid(loc_out_valid), .loc_out_ready(loc_out_ready), .loc_out_data(loc_out_data),
    .byp_in_valid(byp_in_valid), .byp_in_ready(byp_in_ready), .byp_in_data(byp_in_data),
    .byp_out_valid(byp_out_valid), .byp_out_ready(byp_out_ready), .byp_out_data(byp_out_data)
  );

  // output-side instance signals
  logic [1:0]   o_src = 2'd0;
  logic [2:0]   o_mask = 3'b001;
  logic         o_net_in_valid = 1'b0, o_net_in_ready;
  logic [W-1:0] o_net_in_data = '0;
  logic         o_net_out_valid;
  logic [W-1:0] o_net_out_data;
  logic         o_loc_in_ready, o_loc_out_valid;
  logic [W-1:0] o_loc_out_data;
  logic         o_byp_in_valid = 1'b0, o_byp_in_ready;
  logic [W-1:0] o_byp_in_data = '0;
  logic         o_byp_out_valid;
  logic [W-1:0] o_byp_out_data;

  ntc_link_cell #(.DATA_W(W), .OUTPUT_SIDE(1'b1)) i_ntc_link_cell_out (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_sel(o_src), .cfg_dest_mask(o_mask),
    .net_in_valid(o_net_in_valid), .net_in_ready(o_net_in_ready), .net_in_data(o_net_in_data),
    .net_out_valid(o_net_out_valid), .net_out_ready(1'b1), .net_out_data(o_net_out_data),
    .loc_in_valid(1'b0), .loc_in_ready(o_loc_in_ready), .loc_in_data('0),
    .loc_out_valid(o_loc_out_valid), .loc_out_ready(1'b1), .loc_out_data(o_loc_out_data),
    .byp_in_valid(o_byp_in_valid), .byp_in_ready(o_byp_in_ready), .byp_in_data(o_byp_in_data),
    .byp_out_valid(o_byp_out_valid), .byp_out_ready(1'b1), .byp_out_data(o_byp_out_data)
  );

  // sink readiness: 0 always ready, 1 pseudo-random, 2 held low
  int st_net = 0, st_loc = 0, st_byp = 0;
  function automatic logic rdy_of(int mode, int salt);
    if (mode == 0) return 1'b1;
    if (mode == 2) return 1'b0;
    return logic'(((cyc * 5 + salt) ^ (cyc >> 1)) & 1);
  endfunction
  initial begin net_out_ready = 1'b1; loc_out_ready = 1'b1; byp_out_ready = 1'b1; end
  always @(negedge clk) begin
    #1;
    net_out_ready = rdy_of(st_net, 0);
    loc_out_ready = rdy_of(st_loc, 1);
    byp_out_ready = rdy_of(st_byp, 3);
  end

  logic [W-1:0] q_net[$], q_loc[$], q_byp[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk); #4;
  endtask

  // scoreboard monitor: samples 1 ns before each rising edge
  always begin
    @(negedge clk); #4;
    if (rst_n && net_out_valid && net_out_ready) begin
      if (q_net.size() == 0) chk(0, "R2/R3 net_out unexpected flit", 64'(net_out_data), 0);
      else begin logic [W-1:0] e; e = q_net.pop_front(); chk(net_out_data == e, "R2/R3 net_out data", 64'(net_out_data), 64'(e)); end
    end
    if (rst_n && loc_out_valid && loc_out_ready) begin
      if (q_loc.size() == 0) chk(0, "R4 loc_out unexpected flit", 64'(loc_out_data), 0);
      else begin logic [W-1:0] e; e = q_loc.pop_front(); chk(loc_out_data == e, "R4 loc_out data", 64'(loc_out_data), 64'(e)); end
    end
    if (rst_n && byp_out_valid && byp_out_ready) begin
      if (q_byp.size() == 0) chk(0, "R8 byp_out unexpected flit", 64'(byp_out_data), 0);
      else begin logic [W-1:0] e; e = q_byp.pop_front(); chk(byp_out_data == e, "R8 byp_out data", 64'(byp_out_data), 64'(e)); end
    end
  end

  int acc_cyc = 0;

  // driver: holds the flit until accepted, then records where it must go
  task automatic send_net(input logic [W-1:0] d);
    @(negedge clk); net_in_valid = 1'b1; net_in_data = d;
    #4;
    while (!net_in_ready) begin @(negedge clk); #4; end
    acc_cyc = cyc;
    if (cfg_dest_mask[0] && cfg_src_sel == 2'd0) q_net.push_back(d);
    if (cfg_dest_mask[1]) q_loc.push_back(d);
    if (cfg_dest_mask[2]) q_byp.push_back(d);
  endtask

  task automatic send_loc(input logic [W-1:0] d);
    @(negedge clk); loc_in_valid = 1'b1; loc_in_data = d;
    #4;
    while (!loc_in_ready) begin @(negedge clk); #4; end
    q_net.push_back(d);
  endtask

  task automatic net_idle(); @(negedge clk); net_in_valid = 1'b0; endtask
  task automatic loc_idle(); @(negedge clk); loc_in_valid = 1'b0; endtask
  task automatic drain(); repeat (30) @(negedge clk); endtask

  task automatic set_cfg(input logic [1:0] s, input logic [2:0] m);
    @(negedge clk); cfg_src_sel = s; cfg_dest_mask = m;
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int first_acc;
    // R1 reset
    repeat (3) sample();
    chk(!net_out_valid && !loc_out_valid && !byp_out_valid, "R1 outputs idle in reset",
        {net_out_valid, loc_out_valid, byp_out_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    #4;
    chk(!net_out_valid && !loc_out_valid && !byp_out_valid, "R1 outputs idle after reset",
        {net_out_valid, loc_out_valid, byp_out_valid}, 0);
    chk(net_in_ready == 1'b1, "R1 pass-through ready after reset", net_in_ready, 1);

    // R2 latency of one flit
    send_net(34'h2_1234_5678);
    net_idle(); #4;
    chk(net_out_valid && net_out_data == 34'h2_1234_5678, "R2 one-cycle latency",
        64'(net_out_data), 64'h2_1234_5678);
    drain();

    // R2 throughput, R5 unselected byp_out ready ignored
    st_byp = 2;
    send_net(34'h100);
    first_acc = acc_cyc;
    for (int i = 1; i < 16; i++) send_net(34'(34'h100 + i));
    net_idle();
    chk(acc_cyc - first_acc == 15, "R2 one flit per cycle", acc_cyc - first_acc, 15);
    drain();
    chk(!byp_out_valid, "R5 unselected sink untouched", byp_out_valid, 0);
    st_byp = 0;

    // R6 hold under stall
    st_net = 2;
    send_net(34'h3_0000_00AA);
    net_idle();
    for (int i = 0; i < 3; i++) begin
      #4;
      chk(net_out_valid && net_out_data == 34'h3_0000_00AA, "R6 held flit stable",
          64'(net_out_data), 64'h3_0000_00AA);
      @(negedge clk);
    end
    st_net = 1;
    for (int i = 0; i < 20; i++) send_net(34'(34'h0_5555_0000 + i * 17));
    net_idle();
    st_net = 0;
    drain();

    // R4 capture only
    set_cfg(2'd0, 3'b010);
    st_loc = 1;
    for (int i = 0; i < 10; i++) send_net(34'(34'h1_0000_0000 + i * 3));
    net_idle();
    drain();

    // R5 dual fanout, no partial copy
    set_cfg(2'd0, 3'b011);
    st_loc = 2;
    send_net(34'h0_0000_0AAA);
    @(negedge clk); net_in_data = 34'h0_0000_0BBB; #4;
    chk(!net_in_ready, "R5 blocked while one live stage full", net_in_ready, 0);
    sample();
    chk(!net_in_ready, "R5 still blocked", net_in_ready, 0);
    chk(!net_out_valid, "R5 no partial copy on net_out", net_out_valid, 0);
    st_loc = 0;
    net_in_valid = 1'b0;
    drain();
    st_net = 1; st_loc = 1;
    for (int i = 0; i < 20; i++) send_net(34'(34'h2_AAAA_0000 + i));
    net_idle();
    st_net = 0; st_loc = 0;
    drain();

    // R7 config change waits for the held flit
    set_cfg(2'd0, 3'b001);
    st_net = 2;
    send_net(34'h0_0000_1111);
    net_idle();
    set_cfg(2'd0, 3'b010);
    fork
      send_net(34'h0_0000_2222);
      begin
        for (int i = 0; i < 3; i++) begin
          #4;
          chk(!net_in_ready, "R7 no accept while change waits", net_in_ready, 0);
          chk(net_out_valid && net_out_data == 34'h0_0000_1111, "R7 held flit on old path",
              64'(net_out_data), 64'h0_0000_1111);
          @(negedge clk);
        end
        st_net = 0;
      end
    join
    net_idle();
    drain();
    chk(q_net.size() == 0 && q_loc.size() == 0, "R7 both flits delivered",
        q_net.size() + q_loc.size(), 0);

    // R3 injection, R10 no live destination
    set_cfg(2'd1, 3'b001);
    repeat (2) @(negedge clk);
    #4;
    chk(!net_in_ready, "R10 net_in not accepted without live destination", net_in_ready, 0);
    st_net = 1;
    for (int i = 0; i < 8; i++) send_loc(34'(34'h3_3300_0000 + i));
    loc_idle();
    drain();
    set_cfg(2'd1, 3'b011);
    st_loc = 1;
    fork
      begin for (int i = 0; i < 10; i++) send_loc(34'(34'h1_7700_0000 + i)); loc_idle(); end
      begin for (int i = 0; i < 10; i++) send_net(34'(34'h0_9900_0000 + i)); net_idle(); end
    join
    st_net = 0; st_loc = 0;
    drain();

    // R8 bypass output, bypass input never accepted
    set_cfg(2'd0, 3'b100);
    @(negedge clk); byp_in_valid = 1'b1; byp_in_data = 34'h1_DEAD_BEEF;
    st_byp = 1;
    for (int i = 0; i < 8; i++) begin
      send_net(34'(34'h2_BB00_0000 + i));
      chk(!byp_in_ready, "R8 byp_in never ready", byp_in_ready, 0);
    end
    net_idle();
    byp_in_valid = 1'b0;
    st_byp = 0;
    drain();
    chk(q_net.size() + q_loc.size() + q_byp.size() == 0, "R2/R4/R8 all expected flits seen",
        q_net.size() + q_loc.size() + q_byp.size(), 0);

    // R9 output-side variant
    @(negedge clk); o_src = 2'd2; o_mask = 3'b001;
    o_byp_in_valid = 1'b1; o_byp_in_data = 34'h3_CAFE_0001;
    #4;
    while (!o_byp_in_ready) begin @(negedge clk); #4; end
    chk(!o_net_in_ready, "R10 output side net_in blocked", o_net_in_ready, 0);
    @(negedge clk); o_byp_in_valid = 1'b0; #4;
    chk(o_net_out_valid && o_net_out_data == 34'h3_CAFE_0001, "R9 bypass input to net_out",
        64'(o_net_out_data), 64'h3_CAFE_0001);
    @(negedge clk); o_src = 2'd0; o_mask = 3'b101;
    o_net_in_valid = 1'b1; o_net_in_data = 34'h0_0BAD_F00D;
    #4;
    while (!o_net_in_ready) begin @(negedge clk); #4; end
    @(negedge clk); o_net_in_valid = 1'b0; #4;
    chk(o_net_out_valid && o_net_out_data == 34'h0_0BAD_F00D, "R9 forward on output side",
        64'(o_net_out_data), 64'h0_0BAD_F00D);
    chk(!o_byp_out_valid, "R9 mask bit 2 ignored on output side", o_byp_out_valid, 0);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule